// File: doc/BRIEF.md
# Battery Monitor Power-Mode Sequencer

This block chooses when a battery-pack monitor is awake. It has three modes. In Normal it issues a one-cycle measurement strobe once per second. In Sleep it issues the same strobe only once every few seconds, and the number of seconds can be set. In Shutdown it does nothing. Time comes from a slow tick input, and a second is a fixed number of those ticks.

Sleep ends, and the block returns to Normal, in either of two cases. The first is a digitized sense-voltage sample whose magnitude, taken in either current direction, stays above a selectable wake threshold for a programmable number of ticks. The second is an asserted fault flag. A cause register records which of these ended Sleep.

Shutdown ends only when the startup-voltage comparator flag is asserted. The host-present pin is sampled once per second, and a low level on it is reported as present.

Top module: `pm_seq`

## Requirements
- R1: After reset, `mode` is Normal (2'b00), and `meas_strobe`, `wake_cause` and `sys_present` are all 0. `mode` never takes the value 2'b11.
- R2: In Normal, `meas_strobe` pulses for one cycle, in the cycle after every SEC_TICKS-th tick. Counting restarts from zero on every change of mode.
- R3: In Sleep, `meas_strobe` pulses once every `sleep_secs` seconds, counted from entry into Sleep. A value of 0 is treated as 1. No other strobe is issued in Sleep.
- R4: `thr_code` is read as {wake bit, range[1:0]} and selects the threshold in µV:
  - 001 selects 1000.
  - 101 and 010 select 2250.
  - 110 and 011 select 4500.
  - 111 selects 9000.
  A sample counts as over the threshold when its absolute value is strictly greater than the threshold. A sample of either sign can wake the block.
- R5: A current wake occurs on a tick when the most recent valid sample has been over the threshold for `qual_ticks` consecutive ticks (0 is treated as 1). A sample at or below the threshold restarts the count.
- R6: In Sleep, an asserted `fault_in` returns the block to Normal in the next cycle and sets `wake_cause[1]`.
- R7: On a wake, `wake_cause` is set to {fault, current}, so bit 0 marks a current wake. It is cleared to 0 on entry into Sleep.
- R8: In Shutdown there are no strobes, and faults, samples, ticks and sleep commands have no effect. Only `startup_ok` returns the block to Normal.
- R9: `sys_present` is updated to the inverse of `pres_n` only at each one-second boundary in Normal or Sleep. Changes of `pres_n` between boundaries, or during Shutdown, are not seen.
- R10: In Normal, `shutdown_req` moves the block to Shutdown and `sleep_req` moves it to Sleep. If both are asserted in the same cycle, `shutdown_req` wins.
- R11: The unused codes 000 and 100 select the 9000 µV threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | One-cycle pulse from the slow timebase |
| sleep_req | input | 1 | Command to enter Sleep |
| shutdown_req | input | 1 | Command to enter Shutdown |
| sleep_secs | input | IVL_W | Sleep strobe interval, in seconds |
| thr_code | input | 3 | Wake threshold code {wake, range[1:0]} |
| qual_ticks | input | QUAL_W | Wake qualification delay, in ticks |
| sense | input | SMP_W | Signed sense sample, 1 µV per LSB |
| sense_vld | input | 1 | Sense sample valid |
| fault_in | input | 1 | Fault flag |
| startup_ok | input | 1 | Startup-voltage comparator flag |
| pres_n | input | 1 | Host-present pin, low means present |
| mode | output | 2 | 00 Normal, 01 Sleep, 10 Shutdown |
| meas_strobe | output | 1 | Measurement/update strobe |
| wake_cause | output | 2 | {fault, current} cause of the last wake |
| sys_present | output | 1 | Sampled host-present status |

## Verification
The threshold compare is driven, for every code, with a sample exactly at the threshold and with one 1 µV above it, using both signs. This separates a strict from an inclusive compare, shows whether the magnitude is taken, and exposes any mis-mapped code.

Over-threshold runs that are one tick short and are then broken tell a sustained-current count from a single-sample trigger. Strobe tick positions are logged through a scoreboard across Normal, Sleep and Shutdown, which shows the one-second period, the Sleep multiple and the silence in Shutdown. Host-pin changes placed between one-second boundaries show that sampling happens only at the boundary.

// File: rtl/pm_seq.sv
module pm_seq #(
  parameter int SEC_TICKS = 32768,
  parameter int IVL_W     = 8,
  parameter int QUAL_W    = 8,
  parameter int SMP_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              sleep_req,
  input  logic              shutdown_req,
  input  logic [IVL_W-1:0]  sleep_secs,
  input  logic [2:0]        thr_code,
  input  logic [QUAL_W-1:0] qual_ticks,
  input  logic [SMP_W-1:0]  sense,
  input  logic              sense_vld,
  input  logic              fault_in,
  input  logic              startup_ok,
  input  logic              pres_n,
  output logic [1:0]        mode,
  output logic              meas_strobe,
  output logic [1:0]        wake_cause,
  output logic              sys_present
);
  localparam int CNT_W = $clog2(SEC_TICKS + 1);
  localparam logic [1:0] M_NORM = 2'd0, M_SLEEP = 2'd1, M_SHUT = 2'd2;
  localparam logic [SMP_W:0] T1 = (SMP_W+1)'(1000);
  localparam logic [SMP_W:0] T2 = (SMP_W+1)'(2250);
  localparam logic [SMP_W:0] T3 = (SMP_W+1)'(4500);
  localparam logic [SMP_W:0] T4 = (SMP_W+1)'(9000);

  logic [CNT_W-1:0]  sec_cnt;
  logic [IVL_W-1:0]  ivl_cnt;
  logic [QUAL_W-1:0] qcnt;
  logic              over_q;
  logic [1:0]        mode_nx;
  logic [SMP_W:0]    thr;

  wire sec_hit = tick && (sec_cnt == CNT_W'(SEC_TICKS - 1));

  wire [SMP_W:0] sx  = {sense[SMP_W-1], sense};
  wire [SMP_W:0] mag = sense[SMP_W-1] ? (~sx + 1'b1) : sx;

  always_comb begin
    case (thr_code)
      3'b001:         thr = T1;
      3'b101, 3'b010: thr = T2;
      3'b110, 3'b011: thr = T3;
      default:        thr = T4;
    endcase
  end

  wire [QUAL_W:0] qual_lim = (qual_ticks == '0) ? (QUAL_W+1)'(1) : {1'b0, qual_ticks};
  wire [IVL_W:0]  ivl_lim  = (sleep_secs == '0) ? (IVL_W+1)'(1) : {1'b0, sleep_secs};

  wire in_sleep  = (mode == M_SLEEP);
  wire cur_wake  = in_sleep && over_q && tick && (({1'b0, qcnt} + 1'b1) >= qual_lim);
  wire flt_wake  = in_sleep && fault_in;
  wire sleep_due = in_sleep && sec_hit && (({1'b0, ivl_cnt} + 1'b1) >= ivl_lim);

  always_comb begin
    mode_nx = mode;
    case (mode)
      M_NORM:  if (shutdown_req) mode_nx = M_SHUT;
               else if (sleep_req) mode_nx = M_SLEEP;
      M_SLEEP: if (cur_wake || flt_wake) mode_nx = M_NORM;
      M_SHUT:  if (startup_ok) mode_nx = M_NORM;
      default: mode_nx = M_NORM;
    endcase
  end

  wire changing = (mode_nx != mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode        <= M_NORM;
      sec_cnt     <= '0;
      ivl_cnt     <= '0;
      qcnt        <= '0;
      over_q      <= 1'b0;
      meas_strobe <= 1'b0;
      wake_cause  <= 2'b00;
      sys_present <= 1'b0;
    end else begin
      mode        <= mode_nx;
      meas_strobe <= ((mode == M_NORM) && sec_hit) || sleep_due;

      if (changing || mode == M_SHUT) sec_cnt <= '0;
      else if (tick) sec_cnt <= sec_hit ? '0 : sec_cnt + 1'b1;

      if (!in_sleep || changing) ivl_cnt <= '0;
      else if (sec_hit) ivl_cnt <= sleep_due ? '0 : ivl_cnt + 1'b1;

      if (!in_sleep) over_q <= 1'b0;
      else if (sense_vld) over_q <= (mag > thr);

      if (!in_sleep) qcnt <= '0;
      else if (tick) qcnt <= over_q ? qcnt + 1'b1 : '0;

      if (mode == M_NORM && mode_nx == M_SLEEP) wake_cause <= 2'b00;
      else if (in_sleep && mode_nx == M_NORM) wake_cause <= {flt_wake, cur_wake};

      if (mode != M_SHUT && sec_hit) sys_present <= ~pres_n;
    end
  end
endmodule

// File: rtl/pm_seq_chk.sv
module pm_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       meas_strobe,
  input logic [1:0] wake_cause,
  input logic       fault_in,
  input logic       startup_ok,
  input logic       sleep_req,
  input logic       shutdown_req
);
  p_mode_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    meas_strobe |=> !meas_strobe);

  p_fault_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && fault_in) |=> (mode == 2'd0 && wake_cause[1]));

  p_cause_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && sleep_req && !shutdown_req) |=> (mode == 2'd1 && wake_cause == 2'b00));

  p_shut_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !startup_ok) |=> mode == 2'd2);

  p_shut_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |=> (mode != 2'd2 || !meas_strobe));

  p_shut_first_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && shutdown_req) |=> mode == 2'd2);
endmodule

bind pm_seq pm_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .meas_strobe(meas_strobe),
  .wake_cause(wake_cause), .fault_in(fault_in), .startup_ok(startup_ok),
  .sleep_req(sleep_req), .shutdown_req(shutdown_req)
);

// File: tb/pm_seq_test.sv
`timescale 1ns/1ps
module pm_seq_test;
  localparam int SEC = 8;

  logic clk = 0, rst_n = 0, tick = 0, sleep_req = 0, shutdown_req = 0;
  logic [7:0] sleep_secs = 8'd1, qual_ticks = 8'd1;
  logic [2:0] thr_code = 3'b001;
  logic [15:0] sense = '0;
  logic sense_vld = 0, fault_in = 0, startup_ok = 0, pres_n = 1;
  logic [1:0] mode, wake_cause;
  logic meas_strobe, sys_present;

  int errors = 0, checks = 0, tick_num = 0;
  int exp_q[$];

  always #2 clk = ~clk;

  pm_seq #(.SEC_TICKS(SEC)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sleep_req(sleep_req),
    .shutdown_req(shutdown_req), .sleep_secs(sleep_secs), .thr_code(thr_code),
    .qual_ticks(qual_ticks), .sense(sense), .sense_vld(sense_vld),
    .fault_in(fault_in), .startup_ok(startup_ok), .pres_n(pres_n),
    .mode(mode), .meas_strobe(meas_strobe), .wake_cause(wake_cause),
    .sys_present(sys_present));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(negedge clk) begin
    if (rst_n && meas_strobe) begin
      if (exp_q.size() == 0) check(0, "R2/R3 unexpected strobe", tick_num, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        check(e == tick_num, "R2/R3 strobe tick", tick_num, e);
      end
    end
  end

  initial begin
    #(4 * 150000);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) begin tick = 1; tick_num++; end
      @(negedge clk) tick = 0;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk) s = 1;
    @(negedge clk) s = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic put_sample(input int v);
    @(negedge clk) begin sense = 16'(v); sense_vld = 1; end
    @(negedge clk) sense_vld = 0;
    @(negedge clk);
  endtask

  function automatic int thr_of(input logic [2:0] c);
    case (c)
      3'b001: return 1000;
      3'b101, 3'b010: return 2250;
      3'b110, 3'b011: return 4500;
      default: return 9000;
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    check(mode == 2'd0 && !meas_strobe && wake_cause == 0 && !sys_present,
          "R1 reset state", {mode, wake_cause}, 0);
    rst_n = 1;
    @(negedge clk);

    // R2, R9: one-second strobes and host-present sampling in Normal
    pres_n = 0;
    exp_q.push_back(tick_num + SEC);
    exp_q.push_back(tick_num + 2*SEC);
    do_ticks(2*SEC);
    check(sys_present == 1, "R9 present low sampled", sys_present, 1);
    pres_n = 1;
    exp_q.push_back(tick_num + SEC);
    do_ticks(SEC - 1);
    check(sys_present == 1, "R9 no sample mid-second", sys_present, 1);
    do_ticks(1);
    check(sys_present == 0, "R9 sampled at boundary", sys_present, 0);

    // R3: Sleep strobes at a 3-second interval
    sleep_secs = 8'd3;
    pulse(sleep_req);
    check(mode == 2'd1, "R10 sleep command", mode, 1);
    exp_q.push_back(tick_num + 3*SEC);
    exp_q.push_back(tick_num + 6*SEC);
    do_ticks(6*SEC);
    check(mode == 2'd1, "R3 still asleep", mode, 1);

    // R6, R7: fault wake, then cause cleared on entry into Sleep
    sleep_secs = 8'd255;
    pulse(fault_in);
    check(mode == 2'd0, "R6 fault wake mode", mode, 0);
    check(wake_cause == 2'b10, "R6 fault cause", wake_cause, 2);
    pulse(sleep_req);
    check(wake_cause == 2'b00, "R7 cause cleared", wake_cause, 0);

    // R4, R11: every threshold code, at and just above, both signs
    qual_ticks = 8'd1;
    for (int c = 0; c < 8; c++) begin
      int t;
      thr_code = 3'(c);
      t = thr_of(3'(c));
      put_sample(t);
      do_ticks(1);
      check(mode == 2'd1, (c == 0 || c == 4) ? "R11 at threshold no wake" : "R4 at threshold no wake", mode, 1);
      put_sample(-t);
      do_ticks(1);
      check(mode == 2'd1, "R4 negative at threshold no wake", mode, 1);
      put_sample((c % 2) ? -(t + 1) : (t + 1));
      do_ticks(1);
      check(mode == 2'd0, (c == 0 || c == 4) ? "R11 above 9000 wakes" : "R4 above threshold wakes", mode, 0);
      check(wake_cause == 2'b01, "R7 current cause", wake_cause, 1);
      put_sample(0);
      pulse(sleep_req);
    end

    // R5: qualification over three ticks
    thr_code = 3'b001;
    qual_ticks = 8'd3;
    put_sample(2000);
    do_ticks(2);
    put_sample(0);
    do_ticks(1);
    check(mode == 2'd1, "R5 broken run no wake", mode, 1);
    put_sample(2000);
    do_ticks(2);
    check(mode == 2'd1, "R5 short run no wake", mode, 1);
    do_ticks(1);
    check(mode == 2'd0, "R5 qualified wake", mode, 0);
    put_sample(0);

    // R10, R8: Shutdown has priority and ignores everything but startup_ok
    @(negedge clk) begin sleep_req = 1; shutdown_req = 1; end
    @(negedge clk) begin sleep_req = 0; shutdown_req = 0; end
    @(negedge clk);
    check(mode == 2'd2, "R10 shutdown priority", mode, 2);
    pres_n = 0;
    pulse(fault_in);
    put_sample(-30000);
    pulse(sleep_req);
    do_ticks(3*SEC);
    check(mode == 2'd2, "R8 shutdown held", mode, 2);
    check(sys_present == 0, "R9 no sampling in shutdown", sys_present, 0);
    pulse(startup_ok);
    check(mode == 2'd0, "R8 startup exit", mode, 0);
    exp_q.push_back(tick_num + SEC);
    do_ticks(SEC);
    check(sys_present == 1, "R9 sampling resumes", sys_present, 1);

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R2/R3 all strobes seen", exp_q.size(), 0);
    finish_run();
  end
endmodule